// File: doc/BRIEF.md
# Byte-Tagged Data Memory

This block is a synchronous single-port data memory in which every byte of a 32-bit word has its own one-bit security tag. A set tag means the byte is untrusted. Each word is stored as 36 bits: four data bytes plus four tag bits. One address selects both the data and its tags, and there is no separate tag address space. Tag storage therefore adds one eighth to the data storage.

A request is either a read, a normal store or a mark command. A normal store uses a byte-enable mask to write data bytes and their tag bits together, so a byte's data and its tag can only change together. A mark command sets the tags of a byte, an aligned halfword or an aligned word to 1 and leaves the data unchanged. A misaligned mark, or one with an undefined size code, is rejected with an error and changes nothing.

Every request gets a response one cycle later. After reset every tag reads as 0. Data contents are undefined until they are written.

Top module: `tagged_byte_ram`

## Requirements
- R1: After reset is released, `rsp_valid` and `rsp_err` are 0, and every word reads back with tag bits [35:32] equal to 0 until it is written or marked.
- R2: Every accepted request (`req_valid`=1) gives exactly one cycle with `rsp_valid`=1, in the cycle after the request. A cycle without a request gives `rsp_valid`=0 in the following cycle.
- R3: For a read (`req_write`=0, `req_mark`=0), `rsp_rdata` in the next cycle holds {tags[3:0], data[31:0]} of the word at `req_addr[AW-1:2]`. Tag bit 32+i belongs to data byte i (bits 8i+7:8i).
- R4: For a normal store (`req_write`=1, `req_mark`=0), each lane i with `req_be[i]`=1 takes both data byte i and tag bit 32+i from `req_wdata`. Lanes with `req_be[i]`=0 keep their data and tag. A store can clear a tag.
- R5: A write is seen by a read issued in the very next cycle.
- R6: A mark with `req_size`=00 (byte) sets the tag of lane `req_addr[1:0]`. The data and all other tags stay unchanged.
- R7: A mark with `req_size`=01 (halfword) needs `req_addr[0]`=0 and sets the tags of lanes `req_addr[1:0]` and `req_addr[1:0]`+1. A mark with `req_size`=10 (word) needs `req_addr[1:0]`=0 and sets all four tags.
- R8: A mark that is misaligned, or that has `req_size`=11, gives `rsp_err`=1 together with `rsp_valid` and writes nothing. All other requests give `rsp_err`=0.
- R9: When `req_mark`=1, the request is a mark command whatever the value of `req_write`, and `req_be` and the data part of `req_wdata` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = normal store, 0 = read |
| req_mark | input | 1 | 1 = mark-untrusted command |
| req_addr | input | AW | Byte address; bits [AW-1:2] select the word |
| req_size | input | 2 | Mark size: 00 byte, 01 halfword, 10 word, 11 invalid |
| req_be | input | 4 | Lane enables for a normal store |
| req_wdata | input | 36 | Store word {tags[3:0], data[31:0]} |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous mark was rejected |
| rsp_rdata | output | 36 | Read result {tags[3:0], data[31:0]} |

## Verification
The hardest case to reach from the ports is a mark whose lanes overlap tags that are already set, or that lie next to lanes a store has just cleared. Only then does a missing or wrong lane select show up as a wrong value instead of a lucky match. The stimulus first clears the target word with a full store. It then sweeps every size code against every low address offset, reads the word back after each mark, and compares the result with a model computed in the bench. Byte-enable masks are swept through all sixteen values over the same word, with tag bits that change from step to step, so every lane's keep-or-replace choice is seen with both tag values.

// File: rtl/tagged_byte_ram.sv
module tagged_byte_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_mark,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [3:0]    req_be,
  input  logic [35:0]   req_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [35:0]   rsp_rdata
);
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;
  localparam int WIW   = AW - 2;
  localparam int WORDS = 1 << WIW;

  logic [DW-1:0]    data_mem [WORDS];
  logic [LANES-1:0] tag_mem  [WORDS];

  logic [LANES-1:0] mark_lanes;
  logic             mark_ok;

  wire [WIW-1:0] widx = req_addr[AW-1:2];
  wire [1:0]     boff = req_addr[1:0];

  always_comb begin
    mark_lanes = '0;
    mark_ok    = 1'b0;
    case (req_size)
      2'b00: begin mark_lanes = 4'b0001 << boff;             mark_ok = 1'b1;           end
      2'b01: begin mark_lanes = boff[1] ? 4'b1100 : 4'b0011; mark_ok = ~boff[0];       end
      2'b10: begin mark_lanes = 4'b1111;                     mark_ok = (boff == 2'b00); end
      default: ;
    endcase
  end

  wire do_mark  = req_valid & req_mark & mark_ok;
  wire bad_mark = req_valid & req_mark & ~mark_ok;
  wire do_store = req_valid & req_write & ~req_mark;
  wire do_read  = req_valid & ~req_write & ~req_mark;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (do_store && req_be[i])
        data_mem[widx][8*i +: 8] <= req_wdata[8*i +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) tag_mem[w] <= '0;
    end else begin
      for (int i = 0; i < LANES; i++) begin
        if (do_mark && mark_lanes[i])
          tag_mem[widx][i] <= 1'b1;
        else if (do_store && req_be[i])
          tag_mem[widx][i] <= req_wdata[DW + i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_read) rsp_rdata <= {tag_mem[widx], data_mem[widx]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= bad_mark;
    end
  end
endmodule

// File: rtl/tagged_byte_ram_chk.sv
module tagged_byte_ram_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_mark,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_err
);
  assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_idle_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  assert_err_only_mark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_mark) |=> !rsp_err);

  assert_half_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mark && req_size == 2'b01 && req_addr[0]) |=> rsp_err);

  assert_word_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mark && req_size == 2'b10 && req_addr[1:0] != 2'b00) |=> rsp_err);

  assert_byte_mark_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mark && req_size == 2'b00) |=> !rsp_err);
endmodule

bind tagged_byte_ram tagged_byte_ram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mark(req_mark),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/tagged_byte_ram_bench.sv
module tagged_byte_ram_bench;
  localparam int AW = 6;
  localparam int WORDS = 1 << (AW - 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_mark = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [3:0] req_be = '0;
  logic [35:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [35:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [35:0] mdl [WORDS];

  always #2.5 clk = ~clk;

  tagged_byte_ram #(.AW(AW)) u_tagged_byte_ram (.*);

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic mk, input logic [AW-1:0] a,
                       input logic [1:0] sz, input logic [3:0] be, input logic [35:0] wd);
    req_valid = 1; req_write = wr; req_mark = mk; req_addr = a;
    req_size = sz; req_be = be; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_read(input int w, input bit tags_only, input string req);
    issue(0, 0, AW'(w * 4), 2'b00, 4'h0, 36'h0);
    check({req, " valid"}, {35'h0, rsp_valid}, 36'h1);
    check({req, " err"}, {35'h0, rsp_err}, 36'h0);
    if (tags_only) check(req, {32'h0, rsp_rdata[35:32]}, {32'h0, mdl[w][35:32]});
    else           check(req, rsp_rdata, mdl[w]);
  endtask

  task automatic do_store(input int w, input logic [3:0] be, input logic [35:0] wd, input logic mk_too);
    issue(1, mk_too, AW'(w * 4), 2'b00, be, wd);
    check("R2 store valid", {35'h0, rsp_valid}, 36'h1);
    for (int i = 0; i < 4; i++)
      if (be[i]) begin
        mdl[w][8*i +: 8] = wd[8*i +: 8];
        mdl[w][32 + i]   = wd[32 + i];
      end
  endtask

  task automatic do_mark(input int w, input logic [1:0] off, input logic [1:0] sz, input logic wr);
    bit ok;
    logic [3:0] lanes;
    ok = (sz == 2'd0) || (sz == 2'd1 && off[0] == 1'b0) || (sz == 2'd2 && off == 2'd0);
    lanes = (sz == 2'd0) ? (4'd1 << off) : (sz == 2'd1) ? (4'd3 << off) : 4'hF;
    issue(wr, 1, AW'(w * 4 + off), sz, 4'hF, 36'h0_0000_0000);
    check("R8 mark valid", {35'h0, rsp_valid}, 36'h1);
    check(ok ? "R7 mark no err" : "R8 mark err", {35'h0, rsp_err}, {35'h0, !ok});
    if (ok) mdl[w][35:32] = mdl[w][35:32] | lanes;
  endtask

  initial begin
    for (int w = 0; w < WORDS; w++) mdl[w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset valid", {35'h0, rsp_valid}, 36'h0);
    check("R1 reset err", {35'h0, rsp_err}, 36'h0);
    for (int w = 0; w < WORDS; w++) do_read(w, 1, "R1 tags after reset");

    for (int w = 0; w < WORDS; w++)
      do_store(w, 4'hF, {4'(w), 32'h3C00_0000 ^ (32'(w) * 32'h0101_0101)}, 0);
    for (int w = 0; w < WORDS; w++) do_read(w, 0, "R3 full readback");

    for (int b = 0; b < 16; b++) begin
      do_store(3, 4'(b), {4'(~b), 32'(b) * 32'h1122_3344 + 32'h5A}, 0);
      do_read(3, 0, "R4 byte enable");
    end

    do_store(7, 4'hF, 36'h9_DEAD_BEEF, 0);
    do_read(7, 0, "R5 back-to-back");
    do_store(7, 4'h6, 36'h6_0102_0304, 0);
    do_read(7, 0, "R5 back-to-back partial");

    for (int sz = 0; sz < 4; sz++)
      for (int off = 0; off < 4; off++) begin
        do_store(5, 4'hF, {4'h0, 32'h0BAD_F00D + 32'(sz * 4 + off)}, 0);
        do_mark(5, 2'(off), 2'(sz), 0);
        do_read(5, 0, sz == 0 ? "R6 byte mark" : (sz == 3 ? "R8 invalid mark" : "R7 aligned mark"));
      end

    do_store(9, 4'hF, {4'h0, 32'h1357_9BDF}, 0);
    do_mark(9, 2'd1, 2'd0, 0);
    do_mark(9, 2'd2, 2'd1, 0);
    do_read(9, 0, "R6 accumulated marks");
    do_store(9, 4'h4, {4'h0, 32'h00AA_0000}, 0);
    do_read(9, 0, "R4 store clears tag");

    do_store(11, 4'hF, {4'h0, 32'h2468_ACE0}, 0);
    do_mark(11, 2'd0, 2'd2, 1);
    do_read(11, 0, "R9 mark wins over write");
    do_read(12, 0, "R9 neighbour untouched");

    @(negedge clk);
    check("R2 idle no valid", {35'h0, rsp_valid}, 36'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule